// File: doc/BRIEF.md
# DDR Read Capture Window Trainer

This block finds and maintains the sampling offset for read data on a double-data-rate memory bus whose clock is generated by the host. Each 16-bit word comes back as two bytes, one per clock edge. The point at which the returned bytes are captured is set as a whole number of system clocks after the bus grant. The trainer sweeps every candidate offset and issues one training read at each. It compares the sixteen returned bytes with a fixed pattern and records pass or fail in a map. It then moves the live capture offset to the middle of the longest run of passing offsets.

The right offset shifts with bus clock frequency, temperature and voltage, so the trainer does not stop after the first sweep. It repeats the sweep on a fixed system-clock period. It also repeats the sweep at once when a guard byte does not match. A guard byte is a copy of a pattern byte that the datapath places between ordinary transfers and presents for checking while the trainer is idle. If a sweep finds no passing offset at all, the trainer raises an error and keeps the offset it had. The memory command sequence is the job of the bus engine behind the request/grant port. Pad delay lines are not part of this block.

Top module: `rdwin_trainer`

## Requirements
- R1: While `rst_n` is low, `bus_req` is 0, `delay_out` equals INIT_DELAY (0 by default) and all four `status` bits are 0. A sweep starts on the first rising edge after reset is released, so `status[1]` is 1 after that edge.
- R2: Training byte k (k = 0..15) is 0x55 when k mod 4 = 0, 0xAA when k mod 4 = 1, 0x00 when k mod 4 = 2 and 0xFF when k mod 4 = 3. Even k is the rising-edge byte and odd k is the falling-edge byte. An offset passes only if all 16 bytes match, so one wrong byte makes it fail.
- R3: For each read, `bus_req` rises and the trainer waits for `bus_gnt`. The grant edge is the rising edge at which both are 1. For candidate offset d, byte k is sampled at the (1 + d + k·SPACING)-th rising edge after the grant edge. `bus_req` stays high until byte 15 is sampled, then goes low for at least one cycle. Only one read is outstanding at a time.
- R4: A sweep tries offsets 0 to NUM_DELAYS-1 in ascending order. Bit d of `pass_map` holds the result for offset d.
- R5: At the end of a sweep that has at least one pass, `delay_out` becomes start + floor((len-1)/2) of the longest run of consecutive passing offsets. When two runs have the same length, the lower one is chosen.
- R6: A sweep with no pass sets `status[2]` and leaves `delay_out` and `status[0]` unchanged. The next sweep that has a pass clears `status[2]`.
- R7: `status[0]` is set by the first sweep that has a pass and stays set. `status[1]` is 1 from the start of a sweep to its end.
- R8: While idle, when `chk_vld` is 1, `rd_data` is compared with training byte `chk_idx`. A mismatch sets `status[3]` at that edge and starts a sweep at the next edge. A match has no effect. Every sweep clears `status[3]` when it ends.
- R9: With no guard mismatch, `status[1]` stays low for exactly RETRAIN_CYCLES cycles between the end of one sweep and the start of the next.
- R10: `delay_out` changes only at the end of a sweep and never while a sweep is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | output | 1 | Request for one training read |
| bus_gnt | input | 1 | Grant from the bus engine, held while the read runs |
| rd_data | input | 8 | Returned read byte, or guard byte while idle |
| chk_vld | input | 1 | Guard byte on `rd_data` is valid for checking |
| chk_idx | input | 4 | Pattern position the guard byte must match |
| delay_out | output | $clog2(NUM_DELAYS) | Live capture offset in system clocks |
| status | output | 4 | [0] locked, [1] sweeping, [2] no-window error, [3] window suspect |
| pass_map | output | NUM_DELAYS | Pass/fail record of the last sweep |

## Verification
The cases that are hard to create from the ports are the shapes of the pass map: two separate runs, a tie between runs, a window at either end of the range, and no window at all. A real eye would only produce these through timing that drifts in the right way. The bench uses a bus model instead. The model counts reads within a sweep, knows which offset each read belongs to, and returns the pattern aligned to that offset's sample edges only for offsets chosen in a table row. At every other offset it corrupts one chosen byte. Each row is started with a guard mismatch and uses its own grant latency, so the rows also test the guard path and the grant-relative timing.

// File: rtl/rdwin_pkg.sv
package rdwin_pkg;

  localparam int TRAIN_LEN = 16;

  localparam int ST_LOCK = 0;
  localparam int ST_BUSY = 1;
  localparam int ST_ERR  = 2;
  localparam int ST_SUSP = 3;

  typedef enum logic [2:0] {
    TS_IDLE,
    TS_REQ,
    TS_RUN,
    TS_GAP,
    TS_FIN
  } trn_state_e;

  // Byte k of the training burst: 55, AA, 00, FF repeating.
  function automatic logic [7:0] train_byte(input logic [3:0] k);
    case (k[1:0])
      2'd0:    return 8'h55;
      2'd1:    return 8'hAA;
      2'd2:    return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/rdwin_sampler.sv
module rdwin_sampler
  import rdwin_pkg::*;
#(
  parameter int NUM_DELAYS = 128,
  parameter int SPACING    = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [$clog2(NUM_DELAYS)-1:0] cand,
  input  logic [7:0]                    rd_data,
  output logic                          rec_vld,
  output logic                          rec_pass
);
  localparam int DLY_W  = $clog2(NUM_DELAYS);
  localparam int WAIT_W = $clog2(NUM_DELAYS + SPACING);

  logic              active_q;
  logic [WAIT_W-1:0] wait_q;
  logic [3:0]        k_q;
  logic              ok_q;

  logic hit;
  logic match;

  assign hit      = active_q && (wait_q == '0);
  assign match    = (rd_data == train_byte(k_q));
  assign rec_vld  = hit && (k_q == 4'(TRAIN_LEN - 1));
  assign rec_pass = ok_q && match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wait_q   <= '0;
      k_q      <= '0;
      ok_q     <= 1'b0;
    end else if (start) begin
      active_q <= 1'b1;
      wait_q   <= WAIT_W'({1'b0, cand});
      k_q      <= '0;
      ok_q     <= 1'b1;
    end else if (active_q) begin
      if (hit) begin
        ok_q   <= ok_q && match;
        k_q    <= k_q + 4'd1;
        wait_q <= WAIT_W'(SPACING - 1);
        if (k_q == 4'(TRAIN_LEN - 1)) active_q <= 1'b0;
      end else begin
        wait_q <= wait_q - WAIT_W'(1);
      end
    end
  end

  localparam int UNUSED_W = DLY_W;
endmodule

// File: rtl/rdwin_tracker.sv
module rdwin_tracker #(
  parameter int NUM_DELAYS = 128
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          rec_vld,
  input  logic                          rec_pass,
  input  logic [$clog2(NUM_DELAYS)-1:0] rec_idx,
  output logic [NUM_DELAYS-1:0]         pass_map,
  output logic                          found,
  output logic [$clog2(NUM_DELAYS)-1:0] mid
);
  localparam int DLY_W = $clog2(NUM_DELAYS);
  localparam int LEN_W = DLY_W + 1;

  logic [DLY_W-1:0] cur_start, best_start, run_start_nx;
  logic [LEN_W-1:0] cur_len, best_len, run_len_nx;

  function automatic logic [DLY_W-1:0] centre_of(input logic [DLY_W-1:0] s,
                                                 input logic [LEN_W-1:0] n);
    logic [LEN_W-1:0] half;
    half = (n - LEN_W'(1)) >> 1;
    return s + half[DLY_W-1:0];
  endfunction

  assign run_len_nx   = cur_len + LEN_W'(1);
  assign run_start_nx = (cur_len == '0) ? rec_idx : cur_start;
  assign found        = (best_len != '0);
  assign mid          = centre_of(best_start, best_len);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      pass_map   <= '0;
      cur_start  <= '0;
      cur_len    <= '0;
      best_start <= '0;
      best_len   <= '0;
    end else if (rec_vld) begin
      pass_map[rec_idx] <= rec_pass;
      if (rec_pass) begin
        cur_len   <= run_len_nx;
        cur_start <= run_start_nx;
        if (run_len_nx > best_len) begin
          best_len   <= run_len_nx;
          best_start <= run_start_nx;
        end
      end else begin
        cur_len <= '0;
      end
    end
  end
endmodule

// File: rtl/rdwin_guard.sv
module rdwin_guard
  import rdwin_pkg::*;
(
  input  logic       armed,
  input  logic       chk_vld,
  input  logic [3:0] chk_idx,
  input  logic [7:0] rd_data,
  output logic       mism
);
  assign mism = armed && chk_vld && (rd_data != train_byte(chk_idx));
endmodule

// File: rtl/rdwin_trainer.sv
module rdwin_trainer
  import rdwin_pkg::*;
#(
  parameter int NUM_DELAYS     = 128,
  parameter int SPACING        = 4,
  parameter int RETRAIN_CYCLES = 100000,
  parameter int INIT_DELAY     = 0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  output logic                          bus_req,
  input  logic                          bus_gnt,
  input  logic [7:0]                    rd_data,
  input  logic                          chk_vld,
  input  logic [3:0]                    chk_idx,
  output logic [$clog2(NUM_DELAYS)-1:0] delay_out,
  output logic [3:0]                    status,
  output logic [NUM_DELAYS-1:0]         pass_map
);
  localparam int DLY_W = $clog2(NUM_DELAYS);
  localparam int TMR_W = $clog2(RETRAIN_CYCLES + 1);

  trn_state_e       state_q;
  logic [DLY_W-1:0] cand_q;
  logic [DLY_W-1:0] delay_q;
  logic             locked_q, err_q, susp_q, boot_q;
  logic [TMR_W-1:0] tmr_q;

  // Named internal events
  logic             busy, trig, tmr_hit;
  logic             train_start, train_end, grant_evt;
  logic             rec_vld, rec_pass, mism;
  logic             found;
  logic [DLY_W-1:0] mid;

  assign busy        = (state_q != TS_IDLE);
  assign tmr_hit     = (tmr_q == TMR_W'(RETRAIN_CYCLES - 1));
  assign trig        = boot_q || susp_q || tmr_hit;
  assign train_start = (state_q == TS_IDLE) && trig;
  assign train_end   = (state_q == TS_FIN);
  assign grant_evt   = (state_q == TS_REQ) && bus_gnt;

  rdwin_sampler #(.NUM_DELAYS(NUM_DELAYS), .SPACING(SPACING)) u_smp (
    .clk(clk), .rst_n(rst_n), .start(grant_evt), .cand(cand_q),
    .rd_data(rd_data), .rec_vld(rec_vld), .rec_pass(rec_pass)
  );

  rdwin_tracker #(.NUM_DELAYS(NUM_DELAYS)) u_trk (
    .clk(clk), .rst_n(rst_n), .clr(train_start), .rec_vld(rec_vld),
    .rec_pass(rec_pass), .rec_idx(cand_q), .pass_map(pass_map),
    .found(found), .mid(mid)
  );

  rdwin_guard u_grd (
    .armed(!busy), .chk_vld(chk_vld), .chk_idx(chk_idx),
    .rd_data(rd_data), .mism(mism)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= TS_IDLE;
      cand_q   <= '0;
      delay_q  <= DLY_W'(INIT_DELAY);
      locked_q <= 1'b0;
      err_q    <= 1'b0;
      susp_q   <= 1'b0;
      boot_q   <= 1'b1;
      tmr_q    <= '0;
    end else begin
      if (state_q == TS_IDLE && !trig) tmr_q <= tmr_q + TMR_W'(1);
      else                             tmr_q <= '0;

      if (train_end) susp_q <= 1'b0;
      else if (mism) susp_q <= 1'b1;

      case (state_q)
        TS_IDLE: if (trig) begin
          state_q <= TS_REQ;
          cand_q  <= '0;
          boot_q  <= 1'b0;
        end
        TS_REQ: if (bus_gnt) state_q <= TS_RUN;
        TS_RUN: if (rec_vld)
          state_q <= (cand_q == DLY_W'(NUM_DELAYS - 1)) ? TS_FIN : TS_GAP;
        TS_GAP: begin
          cand_q  <= cand_q + DLY_W'(1);
          state_q <= TS_REQ;
        end
        TS_FIN: begin
          if (found) begin
            delay_q  <= mid;
            locked_q <= 1'b1;
            err_q    <= 1'b0;
          end else begin
            err_q <= 1'b1;
          end
          state_q <= TS_IDLE;
        end
        default: state_q <= TS_IDLE;
      endcase
    end
  end

  assign bus_req   = (state_q == TS_REQ) || (state_q == TS_RUN);
  assign delay_out = delay_q;

  always_comb begin
    status          = '0;
    status[ST_LOCK] = locked_q;
    status[ST_BUSY] = busy;
    status[ST_ERR]  = err_q;
    status[ST_SUSP] = susp_q;
  end
endmodule

// File: rtl/rdwin_trainer_chk.sv
module rdwin_trainer_chk #(
  parameter int NUM_DELAYS = 128
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          bus_req,
  input logic [3:0]                    status,
  input logic [$clog2(NUM_DELAYS)-1:0] delay_out,
  input logic                          rec_vld,
  input logic                          rec_pass,
  input logic [$clog2(NUM_DELAYS)-1:0] rec_idx,
  input logic [NUM_DELAYS-1:0]         pass_map
);
  // R10: offset only moves on the edge that ends a sweep
  assert_delay_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(status[1]) |-> $stable(delay_out));

  // R6: an empty sweep keeps the previous offset
  assert_err_keeps_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> $stable(delay_out));

  // R3: requests only come from a running sweep
  assert_req_in_sweep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> status[1]);

  // R3: one result per read, never back to back
  assert_one_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rec_vld |=> !rec_vld);

  // R4: a passing result lands in the map
  assert_map_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_vld && rec_pass) |=> pass_map[$past(rec_idx)]);

  // R8: suspect flag is clear once a sweep has finished
  assert_suspect_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[1]) |-> !status[3]);
endmodule

bind rdwin_trainer rdwin_trainer_chk #(.NUM_DELAYS(NUM_DELAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .status(status),
  .delay_out(delay_out), .rec_vld(rec_vld), .rec_pass(rec_pass),
  .rec_idx(cand_q), .pass_map(pass_map)
);

// File: tb/rdwin_trainer_tb.sv
module rdwin_trainer_tb;
  localparam int ND = 128;
  localparam int SP = 2;
  localparam int RC = 3000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         bus_req, bus_gnt;
  logic [7:0]   rd_data;
  logic         chk_vld;
  logic [3:0]   chk_idx;
  logic [6:0]   delay_out;
  logic [3:0]   status;
  logic [ND-1:0] pass_map;

  int total = 0;
  int bad   = 0;

  // model state
  logic [ND-1:0] good_mask;
  int  flip_k, gnt_lat;
  logic [7:0] guard_byte, mdl_data;
  bit  act;
  int  n_edge, rd_cnt, rd_idx, gwait;

  always #4 clk = ~clk;

  rdwin_trainer #(.NUM_DELAYS(ND), .SPACING(SP), .RETRAIN_CYCLES(RC), .INIT_DELAY(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .rd_data(rd_data), .chk_vld(chk_vld), .chk_idx(chk_idx),
    .delay_out(delay_out), .status(status), .pass_map(pass_map)
  );

  assign rd_data = act ? mdl_data : guard_byte;

  // lo1, hi1, lo2, hi2, flip byte, grant latency, expected offset, expected error
  localparam int VEC [7][8] = '{
    '{ 10,  29,  1,  0,  1, 0,  19, 0},
    '{  5,   9, 50, 57, 15, 3,  53, 0},
    '{ 20,  25, 90, 95,  0, 0,  22, 0},
    '{  1,   0,  1,  0,  7, 1,  22, 1},
    '{  0, 127,  1,  0,  0, 0,  63, 0},
    '{127, 127,  1,  0,  8, 2, 127, 0},
    '{  0,   0, 64, 65,  4, 0,  64, 0}
  };

  function automatic logic [7:0] pat(int k);
    case (k % 4)
      0: return 8'h55;
      1: return 8'hAA;
      2: return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [ND-1:0] mk_mask(int lo1, int hi1, int lo2, int hi2);
    logic [ND-1:0] m = '0;
    for (int d = 0; d < ND; d++)
      if ((d >= lo1 && d <= hi1) || (d >= lo2 && d <= hi2)) m[d] = 1'b1;
    return m;
  endfunction

  function automatic logic [7:0] model_byte(int i, int n);
    int m, k;
    m = n - 1 - i;
    if (m < 0) return 8'h3C;
    k = m / SP;
    if (k >= 16) return 8'h3C;
    if (!good_mask[i] && k == flip_k) return ~pat(k);
    return pat(k);
  endfunction

  // bus engine model: inputs change on the falling edge only
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_gnt = 1'b0; act = 1'b0; gwait = 0; rd_cnt = 0; mdl_data = 8'h3C;
    end else if (!bus_req) begin
      bus_gnt = 1'b0; act = 1'b0; gwait = 0;
    end else if (!bus_gnt) begin
      if (gwait >= gnt_lat) bus_gnt = 1'b1;
      else gwait++;
    end else if (!act) begin
      act = 1'b1; n_edge = 1; rd_idx = rd_cnt % ND; rd_cnt++;
      mdl_data = model_byte(rd_idx, n_edge);
    end else begin
      n_edge++;
      mdl_data = model_byte(rd_idx, n_edge);
    end
  end

  task automatic check(bit ok, string tag, logic [ND-1:0] actv, logic [ND-1:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actv, expv);
    end
  endtask

  task automatic wait_sweep_end();
    while (!status[1]) @(negedge clk);
    while (status[1]) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [6:0] prev_dly;
    int gap;
    rst_n = 1'b0; chk_vld = 1'b0; chk_idx = 4'd0; guard_byte = 8'h00;
    good_mask = '0; flip_k = 0; gnt_lat = 0;
    repeat (3) @(negedge clk);
    check(bus_req == 1'b0, "R1 req in reset", ND'(bus_req), 0);
    check(delay_out == 7'd0, "R1 delay in reset", ND'(delay_out), 0);
    check(status == 4'd0, "R1 status in reset", ND'(status), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(status[1] == 1'b1, "R1 sweep starts after reset", ND'(status[1]), 1);

    // boot sweep sees no window at all
    wait_sweep_end();
    check(status[2] == 1'b1, "R6 empty sweep error", ND'(status[2]), 1);
    check(status[0] == 1'b0, "R7 not locked after empty sweep", ND'(status[0]), 0);
    check(delay_out == 7'd0, "R6 delay kept", ND'(delay_out), 0);
    check(pass_map == '0, "R4 empty map", pass_map, '0);

    // matching guard byte is ignored
    @(negedge clk);
    chk_idx = 4'd6; guard_byte = 8'h00; chk_vld = 1'b1;
    repeat (3) @(negedge clk);
    chk_vld = 1'b0;
    @(negedge clk);
    check(status[3] == 1'b0, "R8 match leaves suspect clear", ND'(status[3]), 0);
    check(status[1] == 1'b0, "R8 match starts no sweep", ND'(status[1]), 0);

    prev_dly = 7'd0;
    for (int v = 0; v < 7; v++) begin
      good_mask = mk_mask(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      flip_k    = VEC[v][4];
      gnt_lat   = VEC[v][5];
      chk_idx = 4'd0; guard_byte = 8'h5A; chk_vld = 1'b1;
      @(negedge clk);
      chk_vld = 1'b0; guard_byte = 8'h00;
      check(status[3] == 1'b1 && status[1] == 1'b0, "R8 mismatch sets suspect",
            ND'(status[3:1]), ND'(3'b100));
      @(negedge clk);
      check(status[1] == 1'b1, "R8 mismatch starts sweep", ND'(status[1]), 1);
      repeat (600) @(negedge clk);
      check(delay_out == prev_dly, "R10 delay held mid-sweep", ND'(delay_out), ND'(prev_dly));
      wait_sweep_end();
      check(delay_out == 7'(VEC[v][6]), "R5 R3 R2 selected offset",
            ND'(delay_out), ND'(VEC[v][6]));
      check(status[2] == 1'(VEC[v][7]), "R6 error flag", ND'(status[2]), ND'(VEC[v][7]));
      check(pass_map == good_mask, "R4 R2 pass map", pass_map, good_mask);
      check(status[0] == 1'b1, "R7 locked", ND'(status[0]), 1);
      check(status[3] == 1'b0, "R8 suspect cleared", ND'(status[3]), 0);
      prev_dly = delay_out;
      @(negedge clk);
    end

    // periodic retrain interval
    wait_sweep_end();
    gap = 0;
    while (!status[1]) begin
      gap++;
      @(negedge clk);
    end
    check(gap == RC, "R9 retrain interval", ND'(gap), ND'(RC));
    check(delay_out == prev_dly, "R10 delay unchanged while idle", ND'(delay_out), ND'(prev_dly));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule